// File: doc/BRIEF.md
# Endpoint Control and Status Word

This block holds the 16-bit control and status word of one endpoint in a full-speed USB device controller. A device with several endpoints instantiates it once per endpoint. Software reaches it through a simple write strobe with a data word and a continuous read value. The transaction engine reaches it through three event strobes that report a finished reception, a finished transmission and whether the reception was a SETUP packet.

Each field of the word reacts to a software write in its own way. Configuration fields take the written value. Handshake status fields and data-toggle bits flip wherever a 1 is written. Completion flags can only be cleared, by writing 0. The SETUP flag ignores software completely. Because of this, one write can change a single field of the word while every other field keeps its value, and no read-modify-write sequence can race the hardware. When the endpoint is double-buffered, software uses the toggle bit of the opposite direction as its buffer pointer and flips it through the same write-1 rule.

A write or an event is sampled on a rising clock edge and appears on the read port after that edge.

Top module: `ep_ctrl_reg`

## Requirements
- R1: Reset, asynchronous and active low, clears the whole word to 0x0000.
- R2: A write loads bits 3:0 (endpoint address), bits 10:9 (type: 00 bulk, 01 control, 10 isochronous, 11 interrupt) and bit 8 (kind) directly from the written value.
- R3: For each bit of the receive handshake status (bits 13:12) and the transmit handshake status (bits 5:4), a write of 1 inverts the bit and a write of 0 keeps it. The encoding is 00 disabled, 01 stall, 10 NAK, 11 valid.
- R4: For the receive toggle (bit 14) and the transmit toggle (bit 6), a write of 1 inverts the bit and a write of 0 keeps it.
- R5: A write of 0 to the receive-complete flag (bit 15) or the transmit-complete flag (bit 7) clears it. A write of 1 leaves it as it was.
- R6: Software writes never change the SETUP flag (bit 11).
- R7: A receive-done event sets bit 15 and inverts bit 14. If bits 13:12 are 11 (valid), they become 10 (NAK). Any other status is left unchanged.
- R8: A transmit-done event sets bit 7 and inverts bit 6. If bits 5:4 are 11, they become 10. Any other status is left unchanged.
- R9: A receive-done event with the SETUP qualifier high sets bit 11. A receive-done event with the qualifier low clears it.
- R10: When a write and an event arrive in the same cycle, the write is applied first and the event is applied to its result. A hardware set of a completion flag therefore overrides a software clear, a toggle hit by both flips twice, and a status that the write makes valid is moved to NAK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write value |
| rd_data | output | 16 | Current word |
| ev_rx_done | input | 1 | Reception completed (one-cycle strobe) |
| ev_setup | input | 1 | Qualifies ev_rx_done as a SETUP reception |
| ev_tx_done | input | 1 | Transmission completed (one-cycle strobe) |

## Verification
The bench writes words that mix ones and zeros across fields that have different write rules. A design that treated a toggle or status bit as plain storage would lose its state when 0 is written, and a design that let 1 set a completion flag would report a transaction that never happened. It drives receive events on endpoints whose status is valid and on endpoints whose status is not valid, because a design that always forces NAK would break a stalled or disabled endpoint. It checks that the SETUP flag comes and goes only with events. It also drives writes and events in the same cycle. A design that let software win would drop a completed transaction, and one that applied the event first would leave a freshly validated endpoint open to a second packet.

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ev_rx_done,
  input  logic         ev_setup,
  input  logic         ev_tx_done
);
  localparam int RXF = 15, RXT = 14, RXS = 12, SUF = 11, TYP = 9, KND = 8;
  localparam int TXF = 7, TXT = 6, TXS = 4;

  logic [W-1:0] q, sw, nx;

  always_comb begin
    sw = q;
    if (wr_en) begin
      sw[RXF]         = q[RXF] & wr_data[RXF];
      sw[RXT]         = q[RXT] ^ wr_data[RXT];
      sw[RXS+:2]      = q[RXS+:2] ^ wr_data[RXS+:2];
      sw[TYP+:2]      = wr_data[TYP+:2];
      sw[KND]         = wr_data[KND];
      sw[TXF]         = q[TXF] & wr_data[TXF];
      sw[TXT]         = q[TXT] ^ wr_data[TXT];
      sw[TXS+:2]      = q[TXS+:2] ^ wr_data[TXS+:2];
      sw[3:0]         = wr_data[3:0];
    end
  end

  always_comb begin
    nx = sw;
    if (ev_rx_done) begin
      nx[RXF] = 1'b1;
      nx[RXT] = ~sw[RXT];
      if (sw[RXS+:2] == 2'b11) nx[RXS+:2] = 2'b10;
      nx[SUF] = ev_setup;
    end
    if (ev_tx_done) begin
      nx[TXF] = 1'b1;
      nx[TXT] = ~sw[TXT];
      if (sw[TXS+:2] == 2'b11) nx[TXS+:2] = 2'b10;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nx;

  assign rd_data = q;

  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> rd_data[RXF]); // R7
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> rd_data[TXF]); // R8
  AST_SETUP_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rx_done |=> $stable(rd_data[SUF])); // R6
  AST_SETUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> rd_data[SUF] == $past(ev_setup)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[3:0])); // R2
  AST_RX_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && !(wr_en && wr_data[RXT])) |=> rd_data[RXT] != $past(rd_data[RXT])); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[RXF] && !(wr_en && !wr_data[RXF])) |=> rd_data[RXF]); // R5
endmodule

// File: tb/tb_ep_ctrl_reg.sv
module tb_ep_ctrl_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ev_rx_done = 1'b0, ev_setup = 1'b0, ev_tx_done = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep_ctrl_reg dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                   .rd_data(rd_data), .ev_rx_done(ev_rx_done), .ev_setup(ev_setup),
                   .ev_tx_done(ev_tx_done));

  task automatic check(input logic [15:0] exp, input string req);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] wd, input logic rx,
                      input logic su, input logic tx);
    @(negedge clk);
    wr_en = we; wr_data = wd; ev_rx_done = rx; ev_setup = su; ev_tx_done = tx;
    @(negedge clk);
    wr_en = 0; wr_data = '0; ev_rx_done = 0; ev_setup = 0; ev_tx_done = 0;
  endtask

  task automatic t_reset;
    check(16'h0000, "R1 reset");
  endtask

  task automatic t_plain;
    step(1, 16'h0505, 0, 0, 0); check(16'h0505, "R2 plain load");
    step(1, 16'h0203, 0, 0, 0); check(16'h0203, "R2 plain reload");
  endtask

  task automatic t_status;
    step(1, 16'h3233, 0, 0, 0); check(16'h3233, "R3 status flip to valid");
    step(1, 16'h1203, 0, 0, 0); check(16'h2233, "R3 single bit flip");
    step(1, 16'h0203, 0, 0, 0); check(16'h2233, "R3 zeros keep");
  endtask

  task automatic t_toggle;
    step(1, 16'h4243, 0, 0, 0); check(16'h6273, "R4 toggles flip");
    step(1, 16'h4203, 0, 0, 0); check(16'h2273, "R4 rx toggle back");
    step(1, 16'h0203, 0, 0, 0); check(16'h2273, "R4 zeros keep");
  endtask

  task automatic t_events;
    step(0, 16'h0000, 0, 0, 1); check(16'h22A3, "R8 tx done valid to NAK");
    step(0, 16'h0000, 1, 0, 0); check(16'hE2A3, "R7 rx done NAK kept");
  endtask

  task automatic t_flags;
    step(1, 16'h8283, 0, 0, 0); check(16'hE2A3, "R5 write one keeps");
    step(1, 16'h0203, 0, 0, 0); check(16'h6223, "R5 write zero clears");
    step(1, 16'h0A03, 0, 0, 0); check(16'h6223, "R6 setup not writable");
  endtask

  task automatic t_setup;
    step(1, 16'h1203, 0, 0, 0); check(16'h7223, "R3 rx to valid");
    step(0, 16'h0000, 1, 1, 0); check(16'hAA23, "R9 setup received");
    step(1, 16'h0203, 0, 0, 0); check(16'h2A23, "R6 setup survives write");
    step(0, 16'h0000, 1, 0, 0); check(16'hE223, "R9 setup cleared by data");
  endtask

  task automatic t_conflict;
    step(1, 16'h4203, 1, 0, 0); check(16'hE223, "R10 rx flag hw wins, toggle twice");
    step(1, 16'h0203, 0, 0, 1); check(16'h62E3, "R10 tx flag hw wins");
    step(1, 16'h1203, 1, 0, 0); check(16'hA263, "R10 validated then NAK");
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 0;
    #1 check(16'h0000, "R1 reset mid-run");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_plain();
    t_status();
    t_toggle();
    t_events();
    t_flags();
    t_setup();
    t_conflict();
    t_reset_again();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule